// File: doc/BRIEF.md
# Delay-Window Random Bit Harvester

This block turns the random turn-on delay of an external volatile switching device into random bits. It drives a repeating excitation pulse of fixed width towards the device. An external comparator raises a flag at some random moment inside each pulse and drops it again when the pulse ends. While the flag and the pulse are both high, a free-running counter advances on every rising edge of the sampling clock. The counter is never cleared between pulses, so its low-order bits toggle quickly and depend strongly on small changes in the delay.

When a pulse ends, the block latches the lowest `HARV_W` counter bits as one output word. It announces the word with a one-cycle strobe. If the counter did not move during the pulse, the word is flagged with an error strobe instead, because the device never switched on. A pulse-timer state machine produces the excitation. Its states are `ST_IDLE`, `ST_PULSE` and `ST_RELAX`:

- `ST_IDLE` goes to `ST_PULSE` on an edge where `enable` is high.
- `ST_PULSE` goes to `ST_RELAX` after the pulse's last cycle.
- `ST_RELAX` goes to `ST_PULSE` after the period's last cycle if `enable` is high, and to `ST_IDLE` otherwise.

Pulse width and period are given in microseconds and converted to cycle counts from the clock frequency parameter. The defaults are a 300 µs pulse every 1000 µs at 11.0592 MHz, with a 16-bit counter and 6 harvested bits.

Top module: `delay_bit_harvester`

## Requirements
- R1: Synchronous active-high `rst` clears the timer, the counter and the output registers. While `rst` is high and on the cycle after it, `excite`, `rnd_valid` and `rnd_err` are 0 and `rnd_word` is 0.
- R2: `excite` stays high for exactly PULSE_CYC = floor(CLK_HZ*PULSE_US/10^6) cycles. Its rising edges repeat every PERIOD_CYC = floor(CLK_HZ*PERIOD_US/10^6) cycles while the train runs.
- R3: The counter increments by one, modulo 2^CNT_W, on each clock edge at which both the synchronized comparator flag and `excite` are high.
- R4: `cmp_flag` has no effect while `excite` is low. A flag raised only during the relax interval leaves the counter, and so the next word, unchanged.
- R5: The counter is not cleared between pulses. Each captured word equals bits [HARV_W-1:0] of the running count at the end of the pulse.
- R6: The word appears on `rnd_word` together with a one-cycle strobe. The strobe is high in the second cycle after the last cycle in which `excite` was high. The word then holds until the next capture.
- R7: If the counter did not advance during a pulse, `rnd_err` pulses for one cycle in place of `rnd_valid`, and `rnd_word` keeps its previous value. `rnd_valid` and `rnd_err` are never high together.
- R8: `cmp_flag` passes through two flops before it gates the counter. If the flag rises d cycles after `excite` is first seen high and stays high to the pulse end, the pulse contributes max(PULSE_CYC-2-d, 0) counts.
- R9: The train starts on the first edge at which `enable` is high in `ST_IDLE`. Dropping `enable` never shortens a pulse or a period: the current period completes, and then `excite` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the pulse train; sampled at period boundaries |
| cmp_flag | input | 1 | Asynchronous comparator flag from the device |
| excite | output | 1 | Excitation pulse to the device |
| rnd_word | output | HARV_W | Last harvested low-order counter bits |
| rnd_valid | output | 1 | One-cycle strobe: new word with at least one count |
| rnd_err | output | 1 | One-cycle strobe: pulse ended without any count |

## Verification
The comparator flag is raised at a different offset inside each pulse. This checks that the pulse's count follows the synchronizer latency exactly, and that the words keep adding onto the previous total instead of restarting.

Several patterns separate the cases that must not be confused:
- A flag raised right at the pulse start distinguishes full-window counting from a late start.
- A flag raised in the last two cycles shows that the synchronizer swallows those cycles and yields an error strobe.
- A pulse with no flag at all yields an error strobe.
- A flag raised only during the relax interval shows that it is ignored.

Dropping `enable` in mid-pulse shows that the pulse and its period still complete before the train stops.

// File: rtl/dbh_pkg.sv
package dbh_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_RELAX = 2'd2
    } exc_state_e;

    function automatic int unsigned us_to_cycles(input int unsigned clk_hz,
                                                 input int unsigned dur_us);
        longint unsigned prod;
        prod = (64'(clk_hz) * 64'(dur_us)) / 64'd1_000_000;
        return int'(prod[31:0]);
    endfunction

endpackage

// File: rtl/dbh_sync2.sv
module dbh_sync2 (
    input  logic clk,
    input  logic rst,
    input  logic raw_in,
    output logic sync_out
);
    logic meta_q;
    logic stable_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q   <= 1'b0;
            stable_q <= 1'b0;
        end else begin
            meta_q   <= raw_in;
            stable_q <= meta_q;
        end
    end

    assign sync_out = stable_q;

    AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_out) |-> $past(raw_in, 2)) else $error("sync latency"); // R8

endmodule

// File: rtl/dbh_pulse_fsm.sv
module dbh_pulse_fsm #(
    parameter int unsigned PULSE_CYC  = 3317,
    parameter int unsigned PERIOD_CYC = 11059
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    output logic excite
);
    import dbh_pkg::*;

    localparam int unsigned TW = $clog2(PERIOD_CYC + 1);

    exc_state_e    state_q, state_d;
    logic [TW-1:0] tcnt_q, tcnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            tcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            tcnt_q  <= tcnt_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        tcnt_d  = tcnt_q;
        unique case (state_q)
            ST_IDLE: begin
                tcnt_d = '0;
                if (enable) state_d = ST_PULSE;
            end
            ST_PULSE: begin
                tcnt_d = tcnt_q + TW'(1);
                if (tcnt_q == TW'(PULSE_CYC - 1)) state_d = ST_RELAX;
            end
            ST_RELAX: begin
                if (tcnt_q == TW'(PERIOD_CYC - 1)) begin
                    tcnt_d  = '0;
                    state_d = enable ? ST_PULSE : ST_IDLE;
                end else begin
                    tcnt_d = tcnt_q + TW'(1);
                end
            end
            default: begin
                state_d = ST_IDLE;
                tcnt_d  = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        excite = (state_q == ST_PULSE);
    end

    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $fell(excite) |-> (tcnt_q == TW'(PULSE_CYC))) else $error("pulse width"); // R2
    AST_PULSE_START: assert property (@(posedge clk) disable iff (rst)
        $rose(excite) |-> (tcnt_q == '0)) else $error("pulse start"); // R2
    AST_NO_EARLY_STOP: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RELAX && tcnt_q != TW'(PERIOD_CYC - 1)) |=> !excite) else $error("early restart"); // R9

endmodule

// File: rtl/dbh_gated_counter.sv
module dbh_gated_counter #(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned HARV_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flag_sync,
    input  logic              excite,
    input  logic              capture,
    output logic [HARV_W-1:0] low_bits,
    output logic              moved
);
    logic [CNT_W-1:0] count_q;
    logic             moved_q;
    logic             gate;

    assign gate = flag_sync & excite;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            moved_q <= 1'b0;
        end else begin
            if (gate) count_q <= count_q + CNT_W'(1);
            if (capture) moved_q <= 1'b0;
            else         moved_q <= moved_q | gate;
        end
    end

    assign low_bits = count_q[HARV_W-1:0];
    assign moved    = moved_q;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        gate |=> (count_q == $past(count_q) + CNT_W'(1))) else $error("count step"); // R3
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !excite |=> $stable(count_q)) else $error("count outside pulse"); // R4

endmodule

// File: rtl/delay_bit_harvester.sv
module delay_bit_harvester #(
    parameter int unsigned CLK_HZ    = 11_059_200,
    parameter int unsigned PULSE_US  = 300,
    parameter int unsigned PERIOD_US = 1000,
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned HARV_W    = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              cmp_flag,
    output logic              excite,
    output logic [HARV_W-1:0] rnd_word,
    output logic              rnd_valid,
    output logic              rnd_err
);
    import dbh_pkg::*;

    localparam int unsigned PULSE_CYC  = us_to_cycles(CLK_HZ, PULSE_US);
    localparam int unsigned PERIOD_CYC = us_to_cycles(CLK_HZ, PERIOD_US);

    logic              flag_sync;
    logic              excite_d;
    logic              capture;
    logic              moved;
    logic [HARV_W-1:0] low_bits;
    logic [HARV_W-1:0] word_q;
    logic              valid_q;
    logic              err_q;

    dbh_sync2 u_sync (
        .clk      (clk),
        .rst      (rst),
        .raw_in   (cmp_flag),
        .sync_out (flag_sync)
    );

    dbh_pulse_fsm #(
        .PULSE_CYC  (PULSE_CYC),
        .PERIOD_CYC (PERIOD_CYC)
    ) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .enable (enable),
        .excite (excite)
    );

    dbh_gated_counter #(
        .CNT_W  (CNT_W),
        .HARV_W (HARV_W)
    ) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .flag_sync (flag_sync),
        .excite    (excite),
        .capture   (capture),
        .low_bits  (low_bits),
        .moved     (moved)
    );

    assign capture = excite_d & ~excite;

    always_ff @(posedge clk) begin
        if (rst) begin
            excite_d <= 1'b0;
            word_q   <= '0;
            valid_q  <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            excite_d <= excite;
            valid_q  <= capture & moved;
            err_q    <= capture & ~moved;
            if (capture && moved) word_q <= low_bits;
        end
    end

    assign rnd_word  = word_q;
    assign rnd_valid = valid_q;
    assign rnd_err   = err_q;

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rnd_valid, rnd_err})) else $error("both strobes"); // R7
    AST_STROBE_TIMING: assert property (@(posedge clk) disable iff (rst)
        (rnd_valid || rnd_err) |-> (!$past(excite) && $past(excite, 2))) else $error("strobe timing"); // R6
    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rnd_valid |-> $stable(rnd_word)) else $error("word moved"); // R6

endmodule

// File: tb/tb_delay_bit_harvester.sv
module tb_delay_bit_harvester;

    localparam int CLK_PERIOD = 10;
    localparam int B_CLK_HZ   = 1_000_000;
    localparam int B_PULSE_US = 30;
    localparam int B_PER_US   = 100;
    localparam int B_CNT_W    = 8;
    localparam int B_HARV_W   = 6;
    localparam int PULSE      = B_CLK_HZ / 1_000_000 * B_PULSE_US;
    localparam int PERIOD     = B_CLK_HZ / 1_000_000 * B_PER_US;
    localparam int CMOD       = 1 << B_CNT_W;
    localparam int HMOD       = 1 << B_HARV_W;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                enable = 1'b0;
    logic                cmp_flag = 1'b0;
    logic                excite;
    logic [B_HARV_W-1:0] rnd_word;
    logic                rnd_valid;
    logic                rnd_err;

    int n_checks = 0;
    int n_errs   = 0;
    bit done     = 0;

    delay_bit_harvester #(
        .CLK_HZ    (B_CLK_HZ),
        .PULSE_US  (B_PULSE_US),
        .PERIOD_US (B_PER_US),
        .CNT_W     (B_CNT_W),
        .HARV_W    (B_HARV_W)
    ) dut (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .cmp_flag  (cmp_flag),
        .excite    (excite),
        .rnd_word  (rnd_word),
        .rnd_valid (rnd_valid),
        .rnd_err   (rnd_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model, one update per rising edge
    bit m_ready = 0;
    bit m_run, m_excd, m_s1, m_s2, m_moved, m_val, m_err;
    bit m_exc, m_gate, m_cap;
    int m_t, m_cnt, m_word;

    always @(posedge clk) begin
        if (rst) begin
            m_run = 0; m_t = 0; m_excd = 0; m_s1 = 0; m_s2 = 0;
            m_cnt = 0; m_moved = 0; m_word = 0; m_val = 0; m_err = 0;
            m_ready = 1;
        end else begin
            m_exc  = m_run && (m_t < PULSE);
            m_gate = m_exc && m_s2;
            m_cap  = !m_exc && m_excd;
            if (m_cap) begin
                m_val = m_moved;
                m_err = !m_moved;
                if (m_moved) m_word = m_cnt % HMOD;
                m_moved = 0;
            end else begin
                m_val = 0;
                m_err = 0;
                m_moved = m_moved || m_gate;
            end
            if (m_gate) m_cnt = (m_cnt + 1) % CMOD;
            m_excd = m_exc;
            m_s2 = m_s1;
            m_s1 = cmp_flag;
            if (!m_run) begin
                if (enable) begin m_run = 1; m_t = 0; end
            end else if (m_t == PERIOD - 1) begin
                m_t = 0;
                m_run = enable;
            end else begin
                m_t = m_t + 1;
            end
        end
    end

    always @(negedge clk) begin
        if (m_ready && !rst && !done) begin
            chk(excite == (m_run && m_t < PULSE), "R2 excite vs model", excite, m_run && m_t < PULSE);
            chk(rnd_word == m_word, "R5 word vs model", rnd_word, m_word);
            chk(rnd_valid == m_val, "R6 valid vs model", rnd_valid, m_val);
            chk(rnd_err == m_err, "R7 err vs model", rnd_err, m_err);
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++;
            n_errs++;
            $display("FAIL R9 watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    initial begin
        int prev_word = 0;
        int cyc = 0;
        int last_rise = -1;
        repeat (3) @(negedge clk);
        chk(excite == 0, "R1 excite in reset", excite, 0);
        chk(rnd_valid == 0 && rnd_err == 0, "R1 strobes in reset", rnd_valid + rnd_err, 0);
        chk(rnd_word == 0, "R1 word in reset", rnd_word, 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        chk(excite == 0, "R9 idle without enable", excite, 0);
        enable = 1'b1;
        @(negedge clk);
        chk(excite == 1, "R9 start on first enable edge", excite, 1);

        for (int i = 0; i < 14; i++) begin
            int d, w, counts;
            bit use_flag;
            while (!excite) begin @(negedge clk); cyc++; end
            if (last_rise >= 0) chk(cyc - last_rise == PERIOD, "R2 period", cyc - last_rise, PERIOD);
            last_rise = cyc;
            use_flag = !(i == 3 || i == 5);
            d = (i == 2) ? 0 : (i == 6) ? PULSE - 2 : (i == 7) ? PULSE - 3 : (i * 7 + 3) % 26;
            w = 0;
            while (excite) begin
                if (use_flag && w == d) cmp_flag = 1'b1;
                w++;
                @(negedge clk); cyc++;
            end
            cmp_flag = 1'b0;
            chk(w == PULSE, "R2 pulse width", w, PULSE);
            counts = use_flag ? ((PULSE - 2 - d) > 0 ? PULSE - 2 - d : 0) : 0;
            @(negedge clk); cyc++;
            if (counts > 0) begin
                chk(rnd_valid == 1 && rnd_err == 0, "R6 valid strobe after pulse", rnd_valid, 1);
                chk(rnd_word == (prev_word + counts) % HMOD, "R8 R5 counts accumulate",
                    rnd_word, (prev_word + counts) % HMOD);
                prev_word = (prev_word + counts) % HMOD;
            end else begin
                chk(rnd_err == 1 && rnd_valid == 0, "R7 error strobe on empty pulse", rnd_err, 1);
                chk(rnd_word == prev_word, "R7 R4 word unchanged", rnd_word, prev_word);
            end
            @(negedge clk); cyc++;
            chk(rnd_valid == 0 && rnd_err == 0, "R6 strobe one cycle", rnd_valid + rnd_err, 0);
            chk(rnd_word == prev_word, "R6 word held", rnd_word, prev_word);
            if (i == 4) begin
                cmp_flag = 1'b1;   // relax-only flag, ignored (R4)
                repeat (20) begin @(negedge clk); cyc++; end
                cmp_flag = 1'b0;
            end
        end

        // stop mid-pulse: the pulse and period complete, then idle (R9)
        while (!excite) @(negedge clk);
        repeat (10) @(negedge clk);
        enable = 1'b0;
        begin
            int w = 10;
            int seen = 0;
            while (excite) begin w++; @(negedge clk); end
            chk(w == PULSE, "R9 pulse not shortened", w, PULSE);
            repeat (3 * PERIOD) begin
                @(negedge clk);
                if (excite) seen++;
            end
            chk(seen == 0, "R9 train stopped", seen, 0);
        end
        enable = 1'b1;
        @(negedge clk);
        chk(excite == 1, "R9 restart", excite, 1);
        repeat (PERIOD) @(negedge clk);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

endmodule